// File: doc/BRIEF.md
# Modulator Instability Flag Generator

This block turns a per-cycle "modulator unstable" indication into an active-high invalid-conversion flag and into a clamp select for the output word path. It runs on the master clock. The rule that shapes the flag depends on which of two modes is in force when an episode starts.

In modulator-only mode, every accepted detection gives a fixed three-cycle pulse. While instability lasts, those pulses repeat with one low cycle between them.

In decimation-filter mode, the flag rises on detection and stays high through a hold-off window. That window gives the downstream filter time to settle after the last unstable cycle. For the whole episode, the clamp select tells the word path to force either the positive or the negative full-scale code, matching the sign of the overrange.

The block contains an episode state machine with three states:
- `ST_IDLE`: no episode is running.
- `ST_PULSE`: the fixed pulse of modulator-only mode.
- `ST_HOLD`: the flag level of filter mode.

Its transitions are:
- **start-pulse** (`ST_IDLE` to `ST_PULSE`): unstable is seen while the mode input is low.
- **start-hold** (`ST_IDLE` to `ST_HOLD`): unstable is seen while the mode input is high.
- **pulse-done** (`ST_PULSE` to `ST_IDLE`): the last pulse cycle has been reached.
- **rearm** (`ST_HOLD` to `ST_HOLD`): unstable is seen again, so the hold-off count returns to zero.
- **hold-done** (`ST_HOLD` to `ST_IDLE`): the hold-off count has expired.

A separate sign register feeds the clamp select.

Top module: `ifg_instability_flag`

## Requirements
- R1: While reset is asserted (active low, asynchronous), `flag` is 0 and `sat_sel` is 2'b00. After reset is released, the block is idle.
- R2: In modulator-only mode (`filt_mode` = 0), an unstable sample taken while idle drives `flag` high from the next cycle for exactly PULSE_CYCLES (3) cycles. `flag` then returns low.
- R3: In modulator-only mode, unstable samples taken during a pulse are absorbed. If instability persists, `flag` repeats a pattern of 3 cycles high and 1 cycle low.
- R4: In filter mode (`filt_mode` = 1), an unstable sample taken while idle drives `flag` high from the next cycle. `flag` stays high for as long as unstable keeps being sampled.
- R5: In filter mode, `flag` stays high for exactly HOLD_CYCLES (5120) cycles after the last cycle in which unstable was sampled, and is low in the cycle after that.
- R6: In filter mode, an unstable sample taken during the hold-off window restarts the full HOLD_CYCLES count.
- R7: `sat_sel` bit 0 requests the positive full-scale word 16'h7FFF, and bit 1 requests the negative full-scale word 16'h8000. While a filter-mode episode is active, exactly one of the two bits is set. Which bit is set follows `ovr_neg` (0 = positive) as sampled in the most recent unstable cycle.
- R8: During modulator-only episodes, and whenever `flag` is low, `sat_sel` is 2'b00.
- R9: The mode is taken at the start of an episode. Changing `filt_mode` part-way through an episode does not change how that episode behaves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| filt_mode | input | 1 | 1 = decimation-filter mode, 0 = modulator-only mode |
| unstable | input | 1 | Modulator unstable indication for this cycle |
| ovr_neg | input | 1 | Overrange sign: 1 = negative, 0 = positive |
| flag | output | 1 | Invalid-conversion flag, active high |
| sat_sel | output | 2 | Clamp select: bit 0 = force 16'h7FFF, bit 1 = force 16'h8000 |

## Verification
A corrupted episode counter shows at `flag` within one episode. In modulator-only mode, a pulse of the wrong width appears within four cycles. In filter mode, a falling edge earlier or later than cycle 5120 after the last unstable sample appears, so the bench tracks the exact edge of each hold-off. A wrong state or sign register shows at once as a clamp select that disagrees with the mode or the polarity at the start of the episode. Every cycle is therefore compared against a bench-side episode model, and directed cases place a detection deep inside a hold-off and flip the mode part-way through each kind of episode.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } ifg_state_e;

    localparam logic [1:0] SAT_NONE = 2'b00;
    localparam logic [1:0] SAT_POS  = 2'b01;
    localparam logic [1:0] SAT_NEG  = 2'b10;
endpackage

// File: rtl/ifg_episode_fsm.sv
module ifg_episode_fsm
    import ifg_pkg::*;
#(
    parameter int PULSE_CYCLES = 3,
    parameter int HOLD_CYCLES  = 5120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       filt_mode,
    input  logic       unstable,
    output ifg_state_e state,
    output logic       flag
);
    localparam int MAX_CNT = (HOLD_CYCLES > PULSE_CYCLES) ? HOLD_CYCLES : PULSE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYCLES - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYCLES - 1);

    ifg_state_e       state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state;
        cnt_d   = cnt_q;
        unique case (state)
            ST_IDLE: begin
                cnt_d = '0;
                if (unstable) begin
                    state_d = filt_mode ? ST_HOLD : ST_PULSE;   // start-hold / start-pulse
                end
            end
            ST_PULSE: begin
                if (cnt_q == PULSE_LAST) begin                    // pulse-done
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (unstable) begin                               // rearm
                    cnt_d = '0;
                end else if (cnt_q == HOLD_LAST) begin            // hold-done
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_PULSE, ST_HOLD: flag = 1'b1;
            default:           flag = 1'b0;
        endcase
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !unstable) |=> !flag);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && unstable && !filt_mode) |=> (flag && state == ST_PULSE));
    assert_pulse_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && cnt_q == PULSE_LAST) |=> !flag);
    assert_hold_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && unstable) |=> (flag && state == ST_HOLD));
    assert_hold_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && cnt_q != HOLD_LAST) |=> flag);
    assert_mode_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && cnt_q != PULSE_LAST) |=> (state == ST_PULSE));
endmodule

// File: rtl/ifg_clamp_sel.sv
module ifg_clamp_sel
    import ifg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       unstable,
    input  logic       ovr_neg,
    input  logic       hold_active,
    output logic [1:0] sat_sel
);
    logic neg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
        end else if (unstable) begin
            neg_q <= ovr_neg;
        end
    end

    always_comb begin
        if (!hold_active) begin
            sat_sel = SAT_NONE;
        end else begin
            sat_sel = neg_q ? SAT_NEG : SAT_POS;
        end
    end

    assert_sat_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sat_sel));
    assert_sat_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && unstable) |=> (sat_sel[1] == $past(ovr_neg)));
endmodule

// File: rtl/ifg_instability_flag.sv
module ifg_instability_flag
    import ifg_pkg::*;
#(
    parameter int PULSE_CYCLES = 3,
    parameter int HOLD_CYCLES  = 5120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       filt_mode,
    input  logic       unstable,
    input  logic       ovr_neg,
    output logic       flag,
    output logic [1:0] sat_sel
);
    ifg_state_e state;
    logic       hold_active;

    ifg_episode_fsm #(
        .PULSE_CYCLES (PULSE_CYCLES),
        .HOLD_CYCLES  (HOLD_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .filt_mode (filt_mode),
        .unstable  (unstable),
        .state     (state),
        .flag      (flag)
    );

    assign hold_active = (state == ST_HOLD);

    ifg_clamp_sel u_clamp (
        .clk         (clk),
        .rst_n       (rst_n),
        .unstable    (unstable),
        .ovr_neg     (ovr_neg),
        .hold_active (hold_active),
        .sat_sel     (sat_sel)
    );

    assert_sat_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_sel != SAT_NONE) |-> flag);
endmodule

// File: tb/ifg_instability_flag_test.sv
`timescale 1ns/1ps
module ifg_instability_flag_test;
    localparam int PULSE = 3;
    localparam int HOLD  = 5120;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       filt_mode = 1'b0;
    logic       unstable = 1'b0;
    logic       ovr_neg = 1'b0;
    logic       flag;
    logic [1:0] sat_sel;

    int  n_vec = 0;
    int  n_bad = 0;
    int  cyc   = 0;
    bit  done  = 0;

    // episode model: 0 idle, 1 pulse, 2 hold
    int  m_kind = 0;
    int  m_rem  = 0;
    bit  m_neg  = 0;

    always #2.5 clk = ~clk;

    ifg_instability_flag #(.PULSE_CYCLES(PULSE), .HOLD_CYCLES(HOLD)) uut (
        .clk (clk), .rst_n (rst_n), .filt_mode (filt_mode),
        .unstable (unstable), .ovr_neg (ovr_neg),
        .flag (flag), .sat_sel (sat_sel)
    );

    function automatic int exp_flag();
        return (m_kind != 0) ? 1 : 0;
    endfunction

    function automatic int exp_sat();
        if (m_kind != 2) return 0;
        return m_neg ? 2 : 1;
    endfunction

    task automatic cmp(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_kind = 0; m_rem = 0; m_neg = 0;
    endtask

    task automatic model_step(bit mode, bit u, bit neg);
        case (m_kind)
            0: if (u) begin
                   m_kind = mode ? 2 : 1;
                   m_rem  = mode ? HOLD : PULSE;
               end
            1: if (m_rem == 1) m_kind = 0; else m_rem--;
            default: begin
                if (u) m_rem = HOLD;
                else if (m_rem == 1) m_kind = 0;
                else m_rem--;
            end
        endcase
        if (u) m_neg = neg;
    endtask

    // check outputs, then drive the inputs for the next edge
    task automatic step(string tag, bit mode, bit u, bit neg);
        string t;
        @(negedge clk);
        if (tag == "") t = (m_kind == 2) ? "R5" : "R2";
        else t = tag;
        cmp({t, " flag"}, int'(flag), exp_flag());
        cmp({(m_kind == 2) ? "R7" : "R8", " sat_sel ", t}, int'(sat_sel), exp_sat());
        filt_mode = mode; unstable = u; ovr_neg = neg;
        model_step(mode, u, neg);
    endtask

    task automatic quiet(string tag, bit mode, int n);
        for (int i = 0; i < n; i++) step(tag, mode, 1'b0, 1'b0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        // R1: reset state
        rst_n = 1'b0; unstable = 1'b1; filt_mode = 1'b1; ovr_neg = 1'b1;
        model_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cmp("R1 flag in reset", int'(flag), 0);
            cmp("R1 sat_sel in reset", int'(sat_sel), 0);
        end
        unstable = 1'b0; filt_mode = 1'b0; ovr_neg = 1'b0;
        rst_n = 1'b1;
        quiet("R1", 1'b0, 4);

        // R2: single pulse
        step("R2", 1'b0, 1'b1, 1'b0);
        quiet("R2", 1'b0, 6);

        // R3: persistent instability, detections inside a pulse absorbed
        for (int i = 0; i < 20; i++) step("R3", 1'b0, 1'b1, 1'b1);
        quiet("R3", 1'b0, 5);

        // R8: modulator-only episodes never clamp
        for (int i = 0; i < 9; i++) step("R8", 1'b0, 1'b1, i[0]);
        quiet("R8", 1'b0, 5);

        // R4/R5: filter mode, negative overrange, then full hold-off
        for (int i = 0; i < 6; i++) step("R4", 1'b1, 1'b1, 1'b1);
        quiet("R5", 1'b1, HOLD + 4);

        // R6: restart inside hold-off; R7 polarity change on rearm
        step("R6", 1'b1, 1'b1, 1'b0);
        quiet("R6", 1'b1, 3000);
        step("R7", 1'b1, 1'b1, 1'b1);
        quiet("R6", 1'b1, HOLD + 4);

        // R9: mode flips mid-episode
        step("R9", 1'b0, 1'b1, 1'b0);
        step("R9", 1'b1, 1'b0, 1'b0);
        quiet("R9", 1'b1, 5);
        step("R9", 1'b1, 1'b1, 1'b0);
        quiet("R9", 1'b0, HOLD + 4);

        // R1: reset during a hold-off
        step("R1", 1'b1, 1'b1, 1'b1);
        quiet("R1", 1'b1, 20);
        @(negedge clk);
        rst_n = 1'b0; unstable = 1'b0;
        model_reset();
        #1;
        cmp("R1 flag after mid-run reset", int'(flag), 0);
        cmp("R1 sat_sel after mid-run reset", int'(sat_sel), 0);
        @(negedge clk);
        rst_n = 1'b1;
        quiet("R1", 1'b0, 3);

        // constrained random segments
        for (int s = 0; s < 40; s++) begin
            bit mode = 1'($urandom_range(0, 1));
            int len  = $urandom_range(50, 800);
            int odds = $urandom_range(2, 60);
            for (int i = 0; i < len; i++) begin
                bit u = ($urandom_range(0, odds - 1) == 0);
                step("", mode, u, 1'($urandom_range(0, 1)));
            end
            if (s % 10 == 9) quiet("R5", 1'b0, HOLD + 2);
        end
        quiet("", 1'b0, 8);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule